// File: doc/BRIEF.md
# Multi-Channel Synchronized Start and Hop Controller

This block controls when four receive channels come out of sleep and when each one takes a new tuning frequency. Each channel has its own sleep flag and two programmable 16-bit countdowns. The start countdown wakes the channel when it expires. The hop countdown copies a pending 32-bit frequency word from a shadow register into the active frequency register when it expires.

A countdown can be armed in two ways. The first is a software sync command written through a simple write-only register port. The second is a rising edge on one of four asynchronous sync pins; each channel picks its own pin. The release time is a fixed number of clocks after the arming event. The software path takes the programmed hold-off plus 6 clocks. The pin path takes the hold-off plus 3 clocks. Several channels, or several devices, can therefore start or hop on the same clock edge. While a countdown runs it ignores further sync events. Software can also write the sleep flags directly at any time.

Register map: `wr_addr = {channel[1:0], select[2:0]}`.
- Per channel, select 0 is the start hold-off, 1 the hop hold-off, 2 the shadow frequency word, and 3 the pin configuration. In the pin configuration, bits 1:0 choose the pin (0 to 3), bit 2 lets that pin arm a start, and bit 3 lets it arm a hop.
- Select 4 writes all sleep flags from data bits 3:0, whatever the channel field holds.
- Select 5 is the command register, whatever the channel field holds. Bits 3:0 are the channel mask, bit 8 requests a start, bit 9 requests a hop, and bit 10 is the sync strobe.

Top module: `rx_sync_start`

## Requirements
- R1: After reset every sleep flag reads 1 and every active frequency word reads 0.
- R2: A write to select 4 loads the sleep flags from data bits 3:0, and the outputs show the new value right after the write's clock edge. A 1 puts a channel to sleep at any time, and a 0 wakes it at once.
- R3: A command write with bit 8 and bit 10 both set clears the sleep flag of each channel in mask bits 3:0 exactly H+6 clock edges after the write edge, where H is that channel's start hold-off. Channels outside the mask are unaffected.
- R4: For a channel whose pin configuration has bit 2 set, a rising edge on the selected pin clears its sleep flag H+3 edges after the first edge that samples the pin high.
- R5: Each channel follows only the pin named in its configuration bits 1:0. Several channels may share one pin, and each keeps its own hold-off.
- R6: A hold-off of 1 gives the shortest release: 7 edges after a software sync and 4 after a pin edge.
- R7: Writing the shadow word does not change the active frequency. A command with bit 9 and bit 10 set copies the shadow word to the active word of each masked channel exactly Hf+6 edges after the write, where Hf is the hop hold-off.
- R8: For a channel whose pin configuration has bit 3 set, a rising edge on the selected pin copies the shadow word to the active word Hf+3 edges after the first edge that samples the pin high.
- R9: A sync event that reaches a channel while its countdown is running is ignored, so the release time is unchanged.
- R10: Only a low-to-high transition arms a countdown. A pin that stays high does not arm again.
- R11: A command with bit 8 set but bit 10 clear, or with bit 10 set but bits 8 and 9 clear, arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address {channel, select} |
| wr_data | input | 32 | Write data |
| sync_pin | input | 4 | Asynchronous sync pins |
| ch_sleep | output | 4 | Per-channel sleep flags, 1 = asleep |
| ch_freq | output | 128 | Active frequency words, channel c at bits [32c+31:32c] |

## Verification
On every cycle, the assertions check the following:
- A sleep flag changes only because of a sleep write or a start expiry.
- An active frequency word changes only one edge after a hop expiry.
- A countdown that is already running keeps decrementing when a new sync event arrives.
- Each expiry and each detected pin edge lasts exactly one cycle.

Only the bench scenarios can show the exact release latencies (H+6 and H+3) and the routing of shared pins. They also show that incomplete command words arm nothing and that a pin held high does not re-arm a channel.

// File: rtl/rx_sync_pkg.sv
package rx_sync_pkg;

   // register select field, low three address bits
   localparam int SEL_W = 3;
   typedef enum logic [SEL_W-1:0] {
      SEL_START_HOLD = 3'd0,
      SEL_HOP_HOLD   = 3'd1,
      SEL_SHADOW     = 3'd2,
      SEL_PINCFG     = 3'd3,
      SEL_SLEEP      = 3'd4,
      SEL_CMD        = 3'd5
   } reg_sel_e;

   // command word bit positions
   localparam int CMD_START_BIT = 8;
   localparam int CMD_HOP_BIT   = 9;
   localparam int CMD_SYNC_BIT  = 10;

   // number of external sync pins and the width of a pin index
   localparam int NUM_PINS = 4;
   localparam int PIN_W    = 2;

   // per-channel pin configuration: [3] hop_en, [2] start_en, [1:0] pin
   typedef struct packed {
      logic             hop_en;
      logic             start_en;
      logic [PIN_W-1:0] pin;
   } pin_cfg_t;

   localparam int CFG_W = $bits(pin_cfg_t);

endpackage

// File: rtl/rx_sync_delay.sv
// Fixed-latency shift pipeline; DEPTH = 0 is a wire.
module rx_sync_delay #(
   parameter int W     = 1,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);

   if (W < 1)     $error("rx_sync_delay: W must be at least 1");
   if (DEPTH < 0) $error("rx_sync_delay: DEPTH must not be negative");

   if (DEPTH == 0) begin : g_wire
      assign d_out = d_in;
   end else begin : g_pipe
      logic [W-1:0] stage_q [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
         end else begin
            stage_q[0] <= d_in;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
         end
      end

      assign d_out = stage_q[DEPTH-1];
   end

endmodule

// File: rtl/rx_sync_pin_edge.sv
// Two-flop synchronizer, rising-edge detect, then PIN_LAT-2 alignment stages.
module rx_sync_pin_edge #(
   parameter int PIN_LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic rise
);

   localparam int ALIGN_DEPTH = PIN_LAT - 2;

   if (PIN_LAT < 3) $error("rx_sync_pin_edge: PIN_LAT must be at least 3");

   logic meta_q, sync_q, prev_q;
   logic rise_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= 1'b0;
         sync_q <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         meta_q <= pin_async;
         sync_q <= meta_q;
         prev_q <= sync_q;
      end
   end

   assign rise_raw = sync_q & ~prev_q;

   rx_sync_delay #(.W(1), .DEPTH(ALIGN_DEPTH)) u_align (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rise_raw),
      .d_out (rise)
   );

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_raw |=> !rise_raw) else $error("pin edge longer than one cycle"); // R10

endmodule

// File: rtl/rx_sync_holdoff.sv
// Programmable countdown: arm loads the value; release pulses when the count is 1 (0 acts as 1).
module rx_sync_holdoff #(
   parameter int HOLD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [HOLD_W-1:0] load_val,
   output logic              fire
);

   if (HOLD_W < 2) $error("rx_sync_holdoff: HOLD_W must be at least 2");

   localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

   logic              running_q;
   logic [HOLD_W-1:0] cnt_q;
   logic              last;

   assign last = (cnt_q <= ONE);
   assign fire = running_q & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         cnt_q     <= '0;
      end else if (running_q) begin
         if (last) running_q <= 1'b0;
         else      cnt_q     <= cnt_q - ONE;
      end else if (arm) begin
         running_q <= 1'b1;
         cnt_q     <= load_val;
      end
   end

   AST_REARM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && !last && arm) |=> (running_q && cnt_q == $past(cnt_q) - ONE))
      else $error("sync event disturbed a running countdown"); // R9

   AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire) else $error("release pulse longer than one cycle"); // R3

endmodule

// File: rtl/rx_sync_regs.sv
// Write-only register file and command decode.
module rx_sync_regs
   import rx_sync_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int HOLD_W = 16,
   parameter int FREQ_W = 32,
   parameter int DATA_W = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [$clog2(NUM_CH)+SEL_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [NUM_CH-1:0][HOLD_W-1:0]  start_hold,
   output logic [NUM_CH-1:0][HOLD_W-1:0]  hop_hold,
   output logic [NUM_CH-1:0][FREQ_W-1:0]  shadow,
   output pin_cfg_t [NUM_CH-1:0]          pin_cfg,
   output logic                           sleep_wr,
   output logic [NUM_CH-1:0]              sleep_val,
   output logic [NUM_CH-1:0]              soft_start,
   output logic [NUM_CH-1:0]              soft_hop
);

   localparam int CH_W = $clog2(NUM_CH);

   logic [SEL_W-1:0] sel;
   logic [CH_W-1:0]  ch;
   logic             cmd_hit;

   assign sel = wr_addr[SEL_W-1:0];
   assign ch  = wr_addr[CH_W+SEL_W-1:SEL_W];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = wr_en && (ch == CH_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            start_hold[c] <= HOLD_W'(1);
            hop_hold[c]   <= HOLD_W'(1);
            shadow[c]     <= '0;
            pin_cfg[c]    <= '0;
         end else if (hit) begin
            case (sel)
               SEL_START_HOLD: start_hold[c] <= wr_data[HOLD_W-1:0];
               SEL_HOP_HOLD:   hop_hold[c]   <= wr_data[HOLD_W-1:0];
               SEL_SHADOW:     shadow[c]     <= wr_data[FREQ_W-1:0];
               SEL_PINCFG:     pin_cfg[c]    <= pin_cfg_t'(wr_data[CFG_W-1:0]);
               default: ;
            endcase
         end
      end
   end

   assign sleep_wr  = wr_en && (sel == SEL_SLEEP);
   assign sleep_val = wr_data[NUM_CH-1:0];

   assign cmd_hit    = wr_en && (sel == SEL_CMD) && wr_data[CMD_SYNC_BIT];
   assign soft_start = (cmd_hit && wr_data[CMD_START_BIT]) ? wr_data[NUM_CH-1:0] : '0;
   assign soft_hop   = (cmd_hit && wr_data[CMD_HOP_BIT])   ? wr_data[NUM_CH-1:0] : '0;

endmodule

// File: rtl/rx_sync_start.sv
module rx_sync_start
   import rx_sync_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int HOLD_W   = 16,
   parameter int FREQ_W   = 32,
   parameter int DATA_W   = 32,
   parameter int SOFT_LAT = 6,
   parameter int PIN_LAT  = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [$clog2(NUM_CH)+SEL_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]                wr_data,
   input  logic [NUM_PINS-1:0]              sync_pin,
   output logic [NUM_CH-1:0]                ch_sleep,
   output logic [NUM_CH*FREQ_W-1:0]         ch_freq
);

   if (NUM_CH < 2 || NUM_CH > CMD_START_BIT)
      $error("rx_sync_start: NUM_CH must lie in 2..8");
   if (DATA_W < FREQ_W || DATA_W < HOLD_W || DATA_W <= CMD_SYNC_BIT)
      $error("rx_sync_start: DATA_W too narrow");
   if (SOFT_LAT < 1) $error("rx_sync_start: SOFT_LAT must be at least 1");
   if (PIN_LAT < 3)  $error("rx_sync_start: PIN_LAT must be at least 3");

   logic [NUM_CH-1:0][HOLD_W-1:0] start_hold, hop_hold;
   logic [NUM_CH-1:0][FREQ_W-1:0] shadow;
   pin_cfg_t [NUM_CH-1:0]         pin_cfg;
   logic                          sleep_wr;
   logic [NUM_CH-1:0]             sleep_val;
   logic [NUM_CH-1:0]             soft_start, soft_hop;
   logic [NUM_CH-1:0]             start_d, hop_d;
   logic [NUM_PINS-1:0]           pin_rise;
   logic [NUM_CH-1:0]             start_fire, hop_fire;
   logic [NUM_CH-1:0]             sleep_q;
   logic [NUM_CH-1:0][FREQ_W-1:0] freq_q;

   rx_sync_regs #(
      .NUM_CH (NUM_CH), .HOLD_W (HOLD_W), .FREQ_W (FREQ_W), .DATA_W (DATA_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .start_hold (start_hold),
      .hop_hold   (hop_hold),
      .shadow     (shadow),
      .pin_cfg    (pin_cfg),
      .sleep_wr   (sleep_wr),
      .sleep_val  (sleep_val),
      .soft_start (soft_start),
      .soft_hop   (soft_hop)
   );

   // software-sync alignment pipeline
   rx_sync_delay #(.W(2*NUM_CH), .DEPTH(SOFT_LAT)) u_soft_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({soft_hop, soft_start}),
      .d_out ({hop_d, start_d})
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      rx_sync_pin_edge #(.PIN_LAT(PIN_LAT)) u_edge (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_async (sync_pin[p]),
         .rise      (pin_rise[p])
      );
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel_rise, start_arm, hop_arm;

      assign sel_rise  = pin_rise[pin_cfg[c].pin];
      assign start_arm = start_d[c] | (pin_cfg[c].start_en & sel_rise);
      assign hop_arm   = hop_d[c]   | (pin_cfg[c].hop_en   & sel_rise);

      rx_sync_holdoff #(.HOLD_W(HOLD_W)) u_start_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .arm      (start_arm),
         .load_val (start_hold[c]),
         .fire     (start_fire[c])
      );

      rx_sync_holdoff #(.HOLD_W(HOLD_W)) u_hop_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .arm      (hop_arm),
         .load_val (hop_hold[c]),
         .fire     (hop_fire[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             sleep_q[c] <= 1'b1;
         else if (sleep_wr)      sleep_q[c] <= sleep_val[c];
         else if (start_fire[c]) sleep_q[c] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           freq_q[c] <= '0;
         else if (hop_fire[c]) freq_q[c] <= shadow[c];
      end

      assign ch_freq[c*FREQ_W +: FREQ_W] = freq_q[c];

      AST_FREQ_ONLY_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(freq_q[c]) |-> $past(hop_fire[c]))
         else $error("active frequency changed without hop expiry"); // R7

      AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(sleep_q[c]) |-> ($past(start_fire[c]) || $past(sleep_wr && !sleep_val[c])))
         else $error("channel woke without cause"); // R3

      AST_SLEEP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sleep_q[c]) |-> $past(sleep_wr && sleep_val[c]))
         else $error("channel slept without a sleep write"); // R2
   end

   assign ch_sleep = sleep_q;

endmodule

// File: tb/rx_sync_start_tb.sv
module rx_sync_start_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [4:0]   wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic [3:0]   sync_pin = '0;
   logic [3:0]   ch_sleep;
   logic [127:0] ch_freq;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam int SEL_START = 0, SEL_HOP = 1, SEL_SHADOW = 2, SEL_CFG = 3;
   localparam int A_SLEEP = 4, A_CMD = 5;
   localparam logic [31:0] C_START = 32'h500, C_HOP = 32'h600;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rx_sync_start u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .sync_pin (sync_pin),
      .ch_sleep (ch_sleep),
      .ch_freq  (ch_freq)
   );

   function automatic logic [31:0] freq_of(int c);
      return ch_freq[c*32 +: 32];
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, exp, cyc);
      end
   endtask

   // write; returns at the negedge after the write edge, e0 = edge count there
   task automatic wr(int addr, logic [31:0] data, output int e0);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr[4:0]; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
      e0 = cyc;
   endtask

   task automatic wr_ch(int c, int sel, logic [31:0] data);
      int e;
      wr(c*8 + sel, data, e);
   endtask

   task automatic wait_to(int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic pin_rise(int p, output int p0);
      @(negedge clk);
      sync_pin[p] = 1'b1;
      @(negedge clk);
      p0 = cyc;
   endtask

   task automatic t_reset;
      for (int c = 0; c < 4; c++) check("R1 freq", freq_of(c), 32'h0);
      check("R1 sleep", {28'h0, ch_sleep}, 32'hF);
   endtask

   task automatic t_sleep_write;
      int e;
      wr(A_SLEEP, 32'h0, e);
      check("R2 wake", {28'h0, ch_sleep}, 32'h0);
      wr(A_SLEEP, 32'hA, e);
      check("R2 partial", {28'h0, ch_sleep}, 32'hA);
      wr(A_SLEEP, 32'hF, e);
      check("R2 sleep", {28'h0, ch_sleep}, 32'hF);
   endtask

   task automatic t_soft_start;
      int e0;
      wr_ch(2, SEL_START, 5);
      wr_ch(0, SEL_START, 20);
      wr(A_CMD, C_START | 32'h5, e0);
      wait_to(e0 + 10); check("R3 ch2 early", ch_sleep[2], 1);
      wait_to(e0 + 11); check("R3 ch2 wake",  ch_sleep[2], 0);
      wait_to(e0 + 25); check("R3 ch0 early", ch_sleep[0], 1);
      wait_to(e0 + 26); check("R3 ch0 wake",  ch_sleep[0], 0);
      check("R3 unmasked", {30'h0, ch_sleep[3], ch_sleep[1]}, 32'h3);
   endtask

   task automatic t_partial_cmd;
      int e0;
      wr(A_SLEEP, 32'hF, e0);
      wr_ch(1, SEL_START, 3);
      wr(A_CMD, 32'h102, e0);
      wr(A_CMD, 32'h402, e0);
      wait_to(e0 + 40);
      check("R11 no arm", {28'h0, ch_sleep}, 32'hF);
   endtask

   task automatic t_min_hold;
      int e0;
      wr_ch(1, SEL_START, 1);
      wr(A_CMD, C_START | 32'h2, e0);
      wait_to(e0 + 6); check("R6 soft early", ch_sleep[1], 1);
      wait_to(e0 + 7); check("R6 soft wake",  ch_sleep[1], 0);
   endtask

   task automatic t_pin_start;
      int e, p0;
      wr(A_SLEEP, 32'hF, e);
      wr_ch(1, SEL_CFG, 32'h6);
      wr_ch(3, SEL_CFG, 32'h6);
      wr_ch(0, SEL_CFG, 32'h5);
      wr_ch(1, SEL_START, 4);
      wr_ch(3, SEL_START, 10);
      pin_rise(2, p0);
      wait_to(p0 + 6);  check("R4 ch1 early", ch_sleep[1], 1);
      wait_to(p0 + 7);  check("R4 ch1 wake",  ch_sleep[1], 0);
      wait_to(p0 + 12); check("R5 ch3 early", ch_sleep[3], 1);
      wait_to(p0 + 13); check("R5 ch3 wake",  ch_sleep[3], 0);
      check("R5 other pin", ch_sleep[0], 1);
   endtask

   task automatic t_pin_level;
      int e;
      wr(A_SLEEP, 32'hF, e);
      wait_to(e + 30);
      check("R10 held high", {28'h0, ch_sleep}, 32'hF);
      sync_pin = '0;
      wr_ch(0, SEL_CFG, 0);
      wr_ch(1, SEL_CFG, 0);
      wr_ch(3, SEL_CFG, 0);
   endtask

   task automatic t_rearm;
      int e0, e1;
      wr_ch(0, SEL_START, 40);
      wr(A_CMD, C_START | 32'h1, e0);
      wait_to(e0 + 10);
      wr(A_CMD, C_START | 32'h1, e1);
      wait_to(e0 + 45); check("R9 early", ch_sleep[0], 1);
      wait_to(e0 + 46); check("R9 wake",  ch_sleep[0], 0);
   endtask

   task automatic t_soft_hop;
      int e0;
      wr_ch(2, SEL_SHADOW, 32'hDEADBEEF);
      repeat (5) @(negedge clk);
      check("R7 shadow only", freq_of(2), 32'h0);
      wr_ch(2, SEL_HOP, 8);
      wr(A_CMD, C_HOP | 32'h4, e0);
      wait_to(e0 + 13); check("R7 early", freq_of(2), 32'h0);
      wait_to(e0 + 14); check("R7 update", freq_of(2), 32'hDEADBEEF);
   endtask

   task automatic t_pin_hop;
      int e, p0;
      wr(A_SLEEP, 32'hF, e);
      wr_ch(1, SEL_CFG, 32'hB);
      wr_ch(1, SEL_SHADOW, 32'h12345678);
      wr_ch(1, SEL_HOP, 2);
      pin_rise(3, p0);
      wait_to(p0 + 4); check("R8 early", freq_of(1), 32'h0);
      wait_to(p0 + 5); check("R8 update", freq_of(1), 32'h12345678);
      wait_to(p0 + 20);
      check("R8 no start", ch_sleep[1], 1);
      sync_pin = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sleep_write();
      t_soft_start();
      t_partial_cmd();
      t_min_hold();
      t_pin_start();
      t_pin_level();
      t_rearm();
      t_soft_hop();
      t_pin_hop();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule